// File: doc/BRIEF.md
# Battery-Domain Seconds Counter with Alarm

This block keeps wall-clock time in the always-on domain. It runs from the 32.768 kHz low-power clock. The count is one 47-bit value, with whole seconds in the upper 32 bits and the fraction of a second in the lower 15 bits, so the count advances once per clock. A seconds-plus-fraction alarm sets a sticky flag when the count reaches it, and that flag can raise an interrupt. Software sees seven 32-bit registers on a simple single-cycle read/write port.

The counter is built to stop rather than to drift. It freezes when the full count rolls over, when the enable bit is clear, while the security controller reports a failure, and after a non-valid indication. Each of these conditions is lifted by its own software action. After a non-valid event, clearing the flag is not enough: software must also write a fresh seconds value, so time restarts only from a value software has chosen. Two lock bits in the control register stop any further writes to the time value.

Register map (word offsets): 0x00 seconds, 0x04 fraction, 0x08 alarm seconds, 0x0C alarm fraction, 0x10 control, 0x14 status, 0x18 interrupt enable. Any other offset reads zero and ignores writes.

Top module: `rtc_time_core`

## Requirements
- R1: While running, the 47-bit count {seconds, fraction} increases by one on every clock. When the fraction wraps to zero, the carry reaches the seconds field on the same edge. Offset 0x00 reads the seconds. Offset 0x04 reads the fraction in bits 14:0, with the upper bits reading zero.
- R2: The count advances only when all of these hold: control bit 3 (enable) is 1, the overflow flag is 0, the non-valid flag is 0, no re-seed is pending, and the failure input is low. Otherwise the count holds its value.
- R3: Status at 0x14 has this layout: bit 0 is the live failure input, bit 1 is the non-valid flag, bit 2 is the overflow flag and bit 4 is the alarm flag. All other bits read 0. Writing 1 to bit 1, 2 or 4 clears that flag, and writing 0 has no effect. If a flag is set and cleared on the same edge, the set wins.
- R4: Reset leaves the count at 0 with the non-valid flag set and a re-seed pending. A high non-valid input sets both again. Once the flag has been cleared, counting resumes only after a write to the seconds register made while the flag is already 0.
- R5: While the failure input is high, the count is frozen and keeps the value it had. Counting continues when the input returns low.
- R6: Control at 0x10 has bit 3 as the enable, bit 17 as the soft lock and bit 18 as the hard lock. Software can set each lock bit but cannot clear it; only reset clears them. While either lock bit is 1, writes to the seconds and fraction registers are ignored.
- R7: Offsets 0x08 and 0x0C hold the alarm seconds and alarm fraction (bits 14:0). The alarm flag (status bit 4) sets on the edge where the advancing count becomes equal to {alarm seconds, alarm fraction}. An alarm seconds value of all ones disables the alarm, and reset loads that value.
- R8: When a running count rolls from all ones to zero, the overflow flag (status bit 2) is set. The count then stays at zero until the flag is cleared.
- R9: alarm_irq is high exactly when the alarm flag is set and bit 4 of the interrupt-enable register at 0x18 is set. It stays high until the flag is cleared.
- R10: A write to seconds or to fraction takes priority over the increment on that edge. The field that was not written keeps its value.
- R11: The seconds field changes only on an edge where the fraction wraps, or on a load. A read therefore never shows a seconds value that does not match the carry out of the fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz low-power clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| sec_fail | input | 1 | Failure indication from the security controller |
| sec_nonvalid | input | 1 | Non-valid indication from the security controller |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The assertions take for granted that sec_fail and sec_nonvalid are already synchronous to clk. They also assume each register write lasts exactly one clock, so a held strobe does not count as repeated writes. The stimulus meets both assumptions: it changes every input only on the falling edge, and it never holds a write for longer than one cycle. A non-valid pulse always lasts a full cycle, and the failure input is held for several cycles.

// File: rtl/rtc_time_pkg.sv
package rtc_time_pkg;

   // register offsets
   localparam int OFS_SEC   = 'h00;
   localparam int OFS_FRAC  = 'h04;
   localparam int OFS_ASEC  = 'h08;
   localparam int OFS_AFRAC = 'h0C;
   localparam int OFS_CTRL  = 'h10;
   localparam int OFS_STAT  = 'h14;
   localparam int OFS_IEN   = 'h18;

   // control fields
   localparam int CTRL_RUN_BIT   = 3;
   localparam int CTRL_SLOCK_BIT = 17;
   localparam int CTRL_HLOCK_BIT = 18;

   // status fields
   localparam int STAT_FAIL_BIT = 0;
   localparam int STAT_NV_BIT   = 1;
   localparam int STAT_OVF_BIT  = 2;
   localparam int STAT_ALM_BIT  = 4;

   // interrupt enable field
   localparam int IEN_ALM_BIT = 4;

   typedef struct packed {
      logic run_en;
      logic soft_lock;
      logic hard_lock;
   } ctrl_t;

   typedef struct packed {
      logic nv;
      logic seed;
      logic ovf;
   } guard_t;

endpackage

// File: rtl/rtc_time_count.sv
module rtc_time_count #(
   parameter int SEC_W       = 32,
   parameter int FRAC_W      = 15,
   parameter int SPLIT_CARRY = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run,
   input  logic                    ld_sec,
   input  logic                    ld_frac,
   input  logic [SEC_W-1:0]        ld_sec_val,
   input  logic [FRAC_W-1:0]       ld_frac_val,
   output logic [SEC_W+FRAC_W-1:0] cnt,
   output logic [SEC_W+FRAC_W-1:0] cnt_nxt,
   output logic                    step,
   output logic                    wrap
);
   localparam int CNT_W = SEC_W + FRAC_W;

   assign step = run & ~ld_sec & ~ld_frac;
   assign wrap = step & (&cnt);

   generate
      if (SPLIT_CARRY != 0) begin : g_split
         logic [SEC_W-1:0]  sec_q;
         logic [FRAC_W-1:0] frac_q;
         logic              frac_cy;

         assign frac_cy = &frac_q;
         assign cnt     = {sec_q, frac_q};
         assign cnt_nxt = {sec_q + SEC_W'(frac_cy), frac_q + FRAC_W'(1)};

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sec_q  <= '0;
               frac_q <= '0;
            end else if (ld_sec || ld_frac) begin
               if (ld_sec)  sec_q  <= ld_sec_val;
               if (ld_frac) frac_q <= ld_frac_val;
            end else if (step) begin
               frac_q <= frac_q + FRAC_W'(1);
               if (frac_cy) sec_q <= sec_q + SEC_W'(1);
            end
         end
      end else begin : g_flat
         logic [CNT_W-1:0] cnt_q;

         assign cnt     = cnt_q;
         assign cnt_nxt = cnt_q + CNT_W'(1);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (ld_sec || ld_frac) begin
               if (ld_sec)  cnt_q[CNT_W-1:FRAC_W] <= ld_sec_val;
               if (ld_frac) cnt_q[FRAC_W-1:0]     <= ld_frac_val;
            end else if (step) begin
               cnt_q <= cnt_nxt;
            end
         end
      end
   endgenerate

   // R2: a stalled count without a load keeps its value
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !ld_sec && !ld_frac) |=> $stable(cnt));

   // R11: seconds move only when the fraction wraps
   a_r11_sec_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_sec && !(&cnt[FRAC_W-1:0])) |=> $stable(cnt[CNT_W-1:FRAC_W]));

   // R8: roll-over lands on zero
   a_r8_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt == '0));

endmodule

// File: rtl/rtc_time_alarm.sv
module rtc_time_alarm #(
   parameter int SEC_W      = 32,
   parameter int FRAC_W     = 15,
   parameter int MATCH_FRAC = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    step,
   input  logic [SEC_W+FRAC_W-1:0] cnt_nxt,
   input  logic [SEC_W-1:0]        alm_sec,
   input  logic [FRAC_W-1:0]       alm_frac,
   input  logic                    clr,
   output logic                    flag
);
   localparam int CNT_W = SEC_W + FRAC_W;

   logic disarmed;
   logic match;
   logic hit;

   assign disarmed = &alm_sec;

   generate
      if (MATCH_FRAC != 0) begin : g_full
         assign match = (cnt_nxt == {alm_sec, alm_frac});
      end else begin : g_sec_only
         assign match = (cnt_nxt[CNT_W-1:FRAC_W] == alm_sec) &&
                        (cnt_nxt[FRAC_W-1:0] == '0);
      end
   endgenerate

   assign hit = step & ~disarmed & match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag <= 1'b0;
      else if (hit)  flag <= 1'b1;
      else if (clr)  flag <= 1'b0;
   end

   // R7: an all-ones alarm seconds value never raises the flag
   a_r7_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
      disarmed |=> !$rose(flag));

   // R3: without a clear request the flag never drops
   a_r3_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);

endmodule

// File: rtl/rtc_time_regs.sv
module rtc_time_regs
   import rtc_time_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 5,
   parameter int SEC_W  = 32,
   parameter int FRAC_W = 15
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_sel,
   input  logic                    bus_we,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [DATA_W-1:0]       bus_wdata,
   output logic [DATA_W-1:0]       bus_rdata,
   input  logic                    fail_in,
   input  logic                    nv_in,
   input  logic [SEC_W+FRAC_W-1:0] cnt,
   input  logic                    wrap,
   input  logic                    alarm_flag,
   output logic                    run,
   output logic                    ld_sec,
   output logic                    ld_frac,
   output logic [SEC_W-1:0]        ld_sec_val,
   output logic [FRAC_W-1:0]       ld_frac_val,
   output logic [SEC_W-1:0]        alm_sec,
   output logic [FRAC_W-1:0]       alm_frac,
   output logic                    alarm_clr,
   output logic                    alarm_ien
);
   localparam int CNT_W = SEC_W + FRAC_W;

   logic   wr_en;
   logic   hit_sec, hit_frac, hit_asec, hit_afrac, hit_ctrl, hit_stat, hit_ien;
   logic   locked;
   logic   stat_wr, clr_nv, clr_ovf;
   ctrl_t  ctrl_q;
   guard_t grd_q;
   logic [SEC_W-1:0]  asec_q;
   logic [FRAC_W-1:0] afrac_q;
   logic              ien_q;

   assign wr_en     = bus_sel & bus_we;
   assign hit_sec   = (bus_addr == ADDR_W'(OFS_SEC));
   assign hit_frac  = (bus_addr == ADDR_W'(OFS_FRAC));
   assign hit_asec  = (bus_addr == ADDR_W'(OFS_ASEC));
   assign hit_afrac = (bus_addr == ADDR_W'(OFS_AFRAC));
   assign hit_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
   assign hit_stat  = (bus_addr == ADDR_W'(OFS_STAT));
   assign hit_ien   = (bus_addr == ADDR_W'(OFS_IEN));

   assign locked      = ctrl_q.soft_lock | ctrl_q.hard_lock;
   assign ld_sec      = wr_en & hit_sec & ~locked;
   assign ld_frac     = wr_en & hit_frac & ~locked;
   assign ld_sec_val  = bus_wdata[SEC_W-1:0];
   assign ld_frac_val = bus_wdata[FRAC_W-1:0];

   assign stat_wr   = wr_en & hit_stat;
   assign clr_nv    = stat_wr & bus_wdata[STAT_NV_BIT];
   assign clr_ovf   = stat_wr & bus_wdata[STAT_OVF_BIT];
   assign alarm_clr = stat_wr & bus_wdata[STAT_ALM_BIT];

   assign run = ctrl_q.run_en & ~grd_q.ovf & ~grd_q.nv & ~grd_q.seed & ~fail_in;

   assign alm_sec   = asec_q;
   assign alm_frac  = afrac_q;
   assign alarm_ien = ien_q;

   // software-owned settings
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         asec_q  <= '1;
         afrac_q <= '0;
         ien_q   <= 1'b0;
      end else if (wr_en) begin
         if (hit_ctrl) begin
            ctrl_q.run_en    <= bus_wdata[CTRL_RUN_BIT];
            ctrl_q.soft_lock <= ctrl_q.soft_lock | bus_wdata[CTRL_SLOCK_BIT];
            ctrl_q.hard_lock <= ctrl_q.hard_lock | bus_wdata[CTRL_HLOCK_BIT];
         end
         if (hit_asec)  asec_q  <= bus_wdata[SEC_W-1:0];
         if (hit_afrac) afrac_q <= bus_wdata[FRAC_W-1:0];
         if (hit_ien)   ien_q   <= bus_wdata[IEN_ALM_BIT];
      end
   end

   // stall conditions
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grd_q.nv   <= 1'b1;
         grd_q.seed <= 1'b1;
         grd_q.ovf  <= 1'b0;
      end else begin
         if (nv_in)       grd_q.nv <= 1'b1;
         else if (clr_nv) grd_q.nv <= 1'b0;

         if (nv_in)                       grd_q.seed <= 1'b1;
         else if (ld_sec && !grd_q.nv)    grd_q.seed <= 1'b0;

         if (wrap)         grd_q.ovf <= 1'b1;
         else if (clr_ovf) grd_q.ovf <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_sec)   bus_rdata[SEC_W-1:0]  = cnt[CNT_W-1:FRAC_W];
      if (hit_frac)  bus_rdata[FRAC_W-1:0] = cnt[FRAC_W-1:0];
      if (hit_asec)  bus_rdata[SEC_W-1:0]  = asec_q;
      if (hit_afrac) bus_rdata[FRAC_W-1:0] = afrac_q;
      if (hit_ctrl) begin
         bus_rdata[CTRL_RUN_BIT]   = ctrl_q.run_en;
         bus_rdata[CTRL_SLOCK_BIT] = ctrl_q.soft_lock;
         bus_rdata[CTRL_HLOCK_BIT] = ctrl_q.hard_lock;
      end
      if (hit_stat) begin
         bus_rdata[STAT_FAIL_BIT] = fail_in;
         bus_rdata[STAT_NV_BIT]   = grd_q.nv;
         bus_rdata[STAT_OVF_BIT]  = grd_q.ovf;
         bus_rdata[STAT_ALM_BIT]  = alarm_flag;
      end
      if (hit_ien)   bus_rdata[IEN_ALM_BIT] = ien_q;
   end

   // R4: when non-valid drops, a fresh seconds value is still owed
   a_r4_seed_owed: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(grd_q.nv) |-> grd_q.seed);

   // R6: lock bits never fall while out of reset
   a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked);

   // R8: a roll-over is always recorded
   a_r8_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> grd_q.ovf);

   // R3: overflow flag kept until cleared
   a_r3_ovf_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (grd_q.ovf && !clr_ovf) |=> grd_q.ovf);

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core #(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 5,
   parameter int SEC_W       = 32,
   parameter int FRAC_W      = 15,
   parameter int SPLIT_CARRY = 1,
   parameter int MATCH_FRAC  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              sec_fail,
   input  logic              sec_nonvalid,
   output logic              alarm_irq
);
   localparam int CNT_W = SEC_W + FRAC_W;

   generate
      if (SEC_W < 1 || SEC_W > DATA_W) begin : g_bad_sec
         $error("rtc_time_core: SEC_W must lie in 1..DATA_W");
      end
      if (FRAC_W < 1 || FRAC_W > DATA_W) begin : g_bad_frac
         $error("rtc_time_core: FRAC_W must lie in 1..DATA_W");
      end
      if (DATA_W < 19) begin : g_bad_data
         $error("rtc_time_core: DATA_W must hold the lock fields");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("rtc_time_core: ADDR_W too small for the register map");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt, cnt_nxt;
   logic              step, wrap, run;
   logic              ld_sec, ld_frac;
   logic [SEC_W-1:0]  ld_sec_val, alm_sec;
   logic [FRAC_W-1:0] ld_frac_val, alm_frac;
   logic              alarm_flag, alarm_clr, alarm_ien;

   rtc_time_regs #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .SEC_W  (SEC_W),
      .FRAC_W (FRAC_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_sel     (bus_sel),
      .bus_we      (bus_we),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .fail_in     (sec_fail),
      .nv_in       (sec_nonvalid),
      .cnt         (cnt),
      .wrap        (wrap),
      .alarm_flag  (alarm_flag),
      .run         (run),
      .ld_sec      (ld_sec),
      .ld_frac     (ld_frac),
      .ld_sec_val  (ld_sec_val),
      .ld_frac_val (ld_frac_val),
      .alm_sec     (alm_sec),
      .alm_frac    (alm_frac),
      .alarm_clr   (alarm_clr),
      .alarm_ien   (alarm_ien)
   );

   rtc_time_count #(
      .SEC_W       (SEC_W),
      .FRAC_W      (FRAC_W),
      .SPLIT_CARRY (SPLIT_CARRY)
   ) u_count (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run),
      .ld_sec      (ld_sec),
      .ld_frac     (ld_frac),
      .ld_sec_val  (ld_sec_val),
      .ld_frac_val (ld_frac_val),
      .cnt         (cnt),
      .cnt_nxt     (cnt_nxt),
      .step        (step),
      .wrap        (wrap)
   );

   rtc_time_alarm #(
      .SEC_W      (SEC_W),
      .FRAC_W     (FRAC_W),
      .MATCH_FRAC (MATCH_FRAC)
   ) u_alarm (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .cnt_nxt  (cnt_nxt),
      .alm_sec  (alm_sec),
      .alm_frac (alm_frac),
      .clr      (alarm_clr),
      .flag     (alarm_flag)
   );

   assign alarm_irq = alarm_flag & alarm_ien;

   // R9: a raised request persists until the flag is cleared or masked
   a_r9_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_irq && !alarm_clr && !(bus_sel && bus_we && bus_addr == ADDR_W'('h18)))
      |=> alarm_irq);

   // R5: failure input freezes the count
   a_r5_fail_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_fail && !ld_sec && !ld_frac) |=> $stable(cnt));

endmodule

// File: tb/sim_rtc_time_core.sv
module sim_rtc_time_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        sec_fail = 1'b0;
   logic        sec_nonvalid = 1'b0;
   logic        alarm_irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   rtc_time_core u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_sel      (bus_sel),
      .bus_we       (bus_we),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .sec_fail     (sec_fail),
      .sec_nonvalid (sec_nonvalid),
      .alarm_irq    (alarm_irq)
   );

   // ---------------- behavioural reference ----------------
   logic [46:0] m_cnt;
   logic [31:0] m_asec;
   logic [14:0] m_afrac;
   bit m_en, m_slk, m_hlk, m_nv, m_seed, m_ovf, m_alm, m_ie;

   always @(posedge clk) begin : model
      bit wr_, ld_s, ld_f, runs, hit, wrapped, stw;
      logic [46:0] n_cnt;
      if (!rst_n) begin
         m_cnt = '0; m_asec = '1; m_afrac = '0;
         m_en = 0; m_slk = 0; m_hlk = 0; m_nv = 1; m_seed = 1;
         m_ovf = 0; m_alm = 0; m_ie = 0;
      end else begin
         wr_  = bus_sel && bus_we;
         ld_s = wr_ && bus_addr == 5'h00 && !(m_slk || m_hlk);
         ld_f = wr_ && bus_addr == 5'h04 && !(m_slk || m_hlk);
         runs = m_en && !m_ovf && !m_nv && !m_seed && !sec_fail;
         stw  = wr_ && bus_addr == 5'h14;
         hit = 0; wrapped = 0; n_cnt = m_cnt;
         if (ld_s || ld_f) begin
            if (ld_s) n_cnt[46:15] = bus_wdata;
            if (ld_f) n_cnt[14:0]  = bus_wdata[14:0];
         end else if (runs) begin
            n_cnt   = m_cnt + 47'd1;
            wrapped = (m_cnt == '1);
            hit     = (m_asec != '1) && (n_cnt == {m_asec, m_afrac});
         end
         if (hit) m_alm = 1; else if (stw && bus_wdata[4]) m_alm = 0;
         if (wrapped) m_ovf = 1; else if (stw && bus_wdata[2]) m_ovf = 0;
         if (sec_nonvalid) m_seed = 1; else if (ld_s && !m_nv) m_seed = 0;
         if (sec_nonvalid) m_nv = 1; else if (stw && bus_wdata[1]) m_nv = 0;
         if (wr_ && bus_addr == 5'h10) begin
            m_en  = bus_wdata[3];
            m_slk = m_slk | bus_wdata[17];
            m_hlk = m_hlk | bus_wdata[18];
         end
         if (wr_ && bus_addr == 5'h08) m_asec  = bus_wdata;
         if (wr_ && bus_addr == 5'h0C) m_afrac = bus_wdata[14:0];
         if (wr_ && bus_addr == 5'h18) m_ie    = bus_wdata[4];
         m_cnt = n_cnt;
      end
   end

   function automatic logic [31:0] m_read(input logic [4:0] a);
      case (a)
         5'h00: return m_cnt[46:15];
         5'h04: return {17'd0, m_cnt[14:0]};
         5'h08: return m_asec;
         5'h0C: return {17'd0, m_afrac};
         5'h10: return {13'd0, m_hlk, m_slk, 13'd0, m_en, 3'd0};
         5'h14: return {27'd0, m_alm, 1'b0, m_ovf, m_nv, sec_fail};
         5'h18: return {27'd0, m_ie, 4'd0};
         default: return 32'd0;
      endcase
   endfunction

   function automatic string tag_of(input logic [4:0] a);
      case (a)
         5'h00, 5'h04: return "R1";
         5'h08, 5'h0C: return "R7";
         5'h10:        return "R6";
         5'h14:        return "R3";
         5'h18:        return "R9";
         default:      return "R1";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   // per-cycle comparison against the reference
   always @(posedge clk) begin
      #5;
      if (rst_n && !done) begin
         chk({tag_of(bus_addr), " model read"}, bus_rdata, m_read(bus_addr));
         chk("R9 model irq", {31'd0, alarm_irq}, {31'd0, m_alm && m_ie});
      end
   end

   // ---------------- bus tasks ----------------
   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_we = 0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_we = 0; bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 0;
      idle(2);
      rst_n = 1;
   endtask

   initial begin : watchdog
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : stim
      logic [31:0] v, w;
      idle(3);
      rst_n = 1;

      // reset state
      rd(5'h14, v); chk("R4 reset status nv", v, 32'h2);
      rd(5'h00, v); chk("R4 reset seconds", v, 32'h0);
      rd(5'h08, v); chk("R7 reset alarm disarmed", v, 32'hFFFF_FFFF);
      chk("R9 reset irq", {31'd0, alarm_irq}, 32'h0);

      // enable but still non-valid / seed pending
      wr(5'h10, 32'h8);
      idle(3);
      rd(5'h04, v); chk("R2 held while non-valid", v, 32'h0);
      wr(5'h14, 32'h2);
      idle(3);
      rd(5'h04, v); chk("R4 seed still owed", v, 32'h0);
      rd(5'h14, v); chk("R3 nv cleared", v, 32'h0);

      // seed and carry
      wr(5'h04, 32'h7FFC);
      wr(5'h00, 32'd5);
      idle(3);
      rd(5'h00, v); chk("R1 carry into seconds", v, 32'd6);
      rd(5'h04, v); chk("R1 fraction after carry", v, 32'd1);

      // write priority
      wr(5'h04, 32'h100);
      rd(5'h04, v); chk("R10 fraction load then step", v, 32'h101);
      rd(5'h00, v); chk("R10 seconds untouched", v, 32'd6);

      // failure freeze
      @(negedge clk) sec_fail = 1;
      rd(5'h04, v);
      idle(5);
      rd(5'h04, w); chk("R5 frozen during failure", w, v);
      rd(5'h14, w); chk("R3 failure bit live", w, 32'h1);
      @(negedge clk) sec_fail = 0;
      rd(5'h04, w); chk("R5 resumes", w, v + 1);

      // soft lock
      wr(5'h10, 32'h0002_0008);
      wr(5'h00, 32'h1234);
      rd(5'h00, v); chk("R6 seconds write refused", v, 32'd6);
      wr(5'h10, 32'h8);
      rd(5'h10, v); chk("R6 soft lock sticky", v, 32'h0002_0008);

      // hard lock
      do_reset();
      wr(5'h10, 32'h0004_0000);
      rd(5'h10, v); chk("R6 hard lock set", v, 32'h0004_0000);
      wr(5'h14, 32'h2);
      wr(5'h00, 32'd9);
      rd(5'h00, v); chk("R6 hard lock refuses write", v, 32'h0);

      // alarm
      do_reset();
      wr(5'h18, 32'h10);
      wr(5'h08, 32'd2);
      wr(5'h0C, 32'd3);
      wr(5'h10, 32'h8);
      wr(5'h14, 32'h2);
      wr(5'h04, 32'h0);
      wr(5'h00, 32'd2);
      idle(10);
      rd(5'h14, v); chk("R7 alarm flag set", v, 32'h10);
      chk("R9 irq raised", {31'd0, alarm_irq}, 32'h1);
      wr(5'h14, 32'h10);
      rd(5'h14, v); chk("R3 alarm cleared", v, 32'h0);
      chk("R9 irq dropped", {31'd0, alarm_irq}, 32'h0);

      // overflow with disarmed alarm on the path
      wr(5'h08, 32'hFFFF_FFFF);
      wr(5'h0C, 32'h7FF8);
      wr(5'h04, 32'h7FF0);
      wr(5'h00, 32'hFFFF_FFFF);
      idle(30);
      rd(5'h00, v); chk("R8 seconds zero after wrap", v, 32'h0);
      rd(5'h14, v); chk("R7 disarmed, R8 overflow flag", v, 32'h4);
      idle(3);
      rd(5'h04, v); chk("R8 frozen at zero", v, 32'h0);
      wr(5'h14, 32'h4);
      rd(5'h04, v); chk("R8 resumes after clear", v, 32'h1);

      // non-valid mid-run
      @(negedge clk) sec_nonvalid = 1;
      @(negedge clk) sec_nonvalid = 0;
      rd(5'h14, v); chk("R4 nv flag raised", v, 32'h2);
      rd(5'h04, v);
      idle(3);
      rd(5'h04, w); chk("R4 frozen while nv", w, v);
      wr(5'h14, 32'h2);
      idle(3);
      rd(5'h04, w); chk("R4 frozen until seed", w, v);
      wr(5'h00, 32'h77);
      rd(5'h00, w); chk("R4 seeded seconds", w, 32'h77);
      rd(5'h04, w); chk("R4 counting after seed", w, v + 2);

      // enable cleared
      wr(5'h10, 32'h0);
      rd(5'h04, v);
      idle(4);
      rd(5'h04, w); chk("R2 held when disabled", w, v);

      idle(2);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule